// File: doc/BRIEF.md
# Banked SPI Control Register Target

This block is a serial-peripheral target that holds the control-register space of a small network controller. It gives a host-side driver a synthesizable counterpart to talk to. Every frame opens with a command byte: an operation code in bits 7:5 and a register address in bits 4:0. Write-style commands take one data byte after it. The target runs in SPI mode 0 with the most significant bit first. The SPI pins are oversampled by the system clock through a synchronizer, so each SCK phase must last several system clocks.

The space has four banks of 27 registers at addresses 0x00 to 0x1A. Five more registers at 0x1B to 0x1F are visible from every bank. Bits 1:0 of the register at 0x1F pick the active bank. A parameter mask marks some banked addresses as slow-class. A read of a slow-class address puts one dummy byte before its data, and the atomic set and clear commands do not touch it. Buffer-memory commands are accepted but change nothing. A one-byte reset command clears the whole space once chip select is released.

Top module: `spi_bank_regfile`

## Requirements
- R1: SPI mode 0 with the MSB first. MOSI is sampled on the rising SCK edge and MISO changes only after a falling SCK edge. The command byte carries the operation in bits 7:5 and the address in bits 4:0.
- R2: Operation 010 writes the second byte of the frame into the addressed register.
- R3: Operation 000 on a register that is not slow-class returns its value on the second byte. The first byte and any byte after the second read as 0x00.
- R4: Operation 000 on a slow-class register returns 0x00 on the second byte and the value on the third byte. With the default mask, bank 2 addresses 0x00 to 0x0F and bank 3 addresses 0x00 to 0x07 are slow-class.
- R5: Addresses 0x00 to 0x1A reach the bank named by bits 1:0 of register 0x1F. A change to those bits applies to the frames that follow.
- R6: Addresses 0x1B to 0x1F reach the same five registers whichever bank is selected.
- R7: Operation 100 ORs the data byte into the register, and operation 101 clears the register bits that are one in the data byte. Neither has any effect on a slow-class register.
- R8: A command byte of 0xFF clears every register, the bank select included, when chip select is released. A frame that ends before that byte is complete clears nothing.
- R9: A write, set or clear frame that ends before its data byte is complete changes no register.
- R10: Buffer commands 001 and 011 change no register, and MISO stays 0x00 during them.
- R11: MISO is high-impedance whenever chip select is inactive (high).
- R12: After a hardware reset every register, the bank select included, reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, high-impedance when not selected |

## Verification
A pin change reaches the logic about three system clocks later: two synchronizer stages plus the edge register. The next byte's MISO value is therefore loaded roughly three clocks after the falling SCK edge that ends a byte. A register update or a reset from a 0xFF command lands about three clocks after chip select rises. The bench holds every SCK half period for eight clocks and samples MISO just before each rising edge. It waits eight clocks after releasing chip select before it checks the idle line or starts the next frame. A behavioural model predicts every returned bit, so each frame is compared only after all of these delays have passed.

// File: rtl/spi_bank_pkg.sv
`timescale 1ns/1ps
package spi_bank_pkg;
   typedef enum logic [2:0] {
      OP_RD_CTRL  = 3'b000,
      OP_RD_BUF   = 3'b001,
      OP_WR_CTRL  = 3'b010,
      OP_WR_BUF   = 3'b011,
      OP_SET_BITS = 3'b100,
      OP_CLR_BITS = 3'b101,
      OP_RSV      = 3'b110,
      OP_SYS      = 3'b111
   } spi_op_e;
   localparam int OP_W = 3;
endpackage

// File: rtl/spi_bank_sync.sv
`timescale 1ns/1ps
module spi_bank_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_pin,
   input  logic cs_n_pin,
   input  logic mosi_pin,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_act,
   output logic cs_start,
   output logic cs_end,
   output logic mosi_s
);
   localparam int CHAIN_W = 3 * STAGES;

   logic [CHAIN_W-1:0] chain_q;
   logic [2:0]         tap;
   logic               sck_d, act_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         sck_d   <= 1'b0;
         act_d   <= 1'b0;
      end else begin
         chain_q <= {chain_q[CHAIN_W-4:0], sck_pin, ~cs_n_pin, mosi_pin};
         sck_d   <= tap[2];
         act_d   <= tap[1];
      end
   end

   assign tap      = chain_q[CHAIN_W-1 -: 3];
   assign cs_act   = tap[1];
   assign mosi_s   = tap[0];
   assign sck_rise = tap[2] & ~sck_d & tap[1];
   assign sck_fall = ~tap[2] & sck_d & tap[1];
   assign cs_start = tap[1] & ~act_d;
   assign cs_end   = ~tap[1] & act_d;
endmodule

// File: rtl/spi_bank_frame.sv
`timescale 1ns/1ps
module spi_bank_frame #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              cs_act,
   input  logic              cs_start,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] tx_next,
   output logic              byte_done,
   output logic [DATA_W-1:0] byte_val,
   output logic [1:0]        byte_idx,
   output logic              miso_bit
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  bit_q;
   logic [DATA_W-1:0] rx_q, tx_q;
   logic [1:0]        idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q     <= '0;
         rx_q      <= '0;
         tx_q      <= '0;
         idx_q     <= '0;
         byte_done <= 1'b0;
         byte_val  <= '0;
         byte_idx  <= '0;
      end else begin
         byte_done <= 1'b0;
         if (cs_start || !cs_act) begin
            bit_q <= '0;
            idx_q <= '0;
            tx_q  <= '0;
         end else begin
            if (sck_rise) begin
               rx_q  <= {rx_q[DATA_W-2:0], mosi_s};
               bit_q <= bit_q + 1'b1;
               if (bit_q == LAST_BIT) begin
                  bit_q     <= '0;
                  byte_done <= 1'b1;
                  byte_val  <= {rx_q[DATA_W-2:0], mosi_s};
                  byte_idx  <= idx_q;
                  if (idx_q != 2'd3) idx_q <= idx_q + 2'd1;
               end
            end
            if (sck_fall)
               tx_q <= (bit_q == '0) ? tx_next : {tx_q[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign miso_bit = tx_q[DATA_W-1];
endmodule

// File: rtl/spi_bank_regs.sv
`timescale 1ns/1ps
module spi_bank_regs
   import spi_bank_pkg::*;
#(
   parameter int NUM_BANKS  = 4,
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 8,
   parameter int NUM_COMMON = 5,
   parameter logic [NUM_BANKS*(2**ADDR_W)-1:0] SLOW_MASK = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         byte_done,
   input  logic [DATA_W-1:0]            byte_val,
   input  logic [1:0]                   byte_idx,
   input  logic                         cs_end,
   output logic [DATA_W-1:0]            tx_next,
   output logic [$clog2(NUM_BANKS)-1:0] bank_sel,
   output logic                         reset_armed
);
   localparam int SPAN     = 2 ** ADDR_W;
   localparam int BANKED   = SPAN - NUM_COMMON;
   localparam int BANK_W   = $clog2(NUM_BANKS);
   localparam int DEPTH    = NUM_BANKS * BANKED + NUM_COMMON;
   localparam int IDX_W    = $clog2(DEPTH);
   localparam int CTRL_IDX = DEPTH - 1;

   logic [DATA_W-1:0]     mem_q [DEPTH];
   logic [OP_W-1:0]       op_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [NUM_BANKS*SPAN-1:0] slow_map;

   // common window never counts as slow-class, whatever the mask holds
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar a = 0; a < SPAN; a++) begin : g_addr
         if (a < BANKED) begin : g_banked
            assign slow_map[b*SPAN+a] = SLOW_MASK[b*SPAN+a];
         end else begin : g_common
            assign slow_map[b*SPAN+a] = 1'b0;
         end
      end
   end

   function automatic logic [IDX_W-1:0] phys(input logic [ADDR_W-1:0] a,
                                             input logic [BANK_W-1:0] b);
      if (int'(a) >= BANKED) return IDX_W'(NUM_BANKS * BANKED + int'(a) - BANKED);
      return IDX_W'(int'(b) * BANKED + int'(a));
   endfunction

   logic [OP_W-1:0]   hdr_op;
   logic [ADDR_W-1:0] hdr_addr;
   logic [IDX_W-1:0]  hdr_idx, cmd_idx;
   logic              hdr_slow, cmd_slow;

   assign bank_sel = mem_q[CTRL_IDX][BANK_W-1:0];
   assign hdr_op   = byte_val[DATA_W-1 -: OP_W];
   assign hdr_addr = byte_val[ADDR_W-1:0];
   assign hdr_idx  = phys(hdr_addr, bank_sel);
   assign cmd_idx  = phys(addr_q, bank_sel);
   assign hdr_slow = slow_map[{bank_sel, hdr_addr}];
   assign cmd_slow = slow_map[{bank_sel, addr_q}];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         op_q        <= '0;
         addr_q      <= '0;
         tx_next     <= '0;
         reset_armed <= 1'b0;
      end else if (cs_end) begin
         reset_armed <= 1'b0;
         if (reset_armed)
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (byte_done) begin
         tx_next <= '0;
         if (byte_idx == 2'd0) begin
            op_q        <= hdr_op;
            addr_q      <= hdr_addr;
            reset_armed <= (byte_val == {DATA_W{1'b1}});
            if (spi_op_e'(hdr_op) == OP_RD_CTRL && !hdr_slow)
               tx_next <= mem_q[hdr_idx];
         end else if (byte_idx == 2'd1) begin
            case (spi_op_e'(op_q))
               OP_RD_CTRL:  if (cmd_slow) tx_next <= mem_q[cmd_idx];
               OP_WR_CTRL:  mem_q[cmd_idx] <= byte_val;
               OP_SET_BITS: if (!cmd_slow) mem_q[cmd_idx] <= mem_q[cmd_idx] | byte_val;
               OP_CLR_BITS: if (!cmd_slow) mem_q[cmd_idx] <= mem_q[cmd_idx] & ~byte_val;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_bank_regfile.sv
`timescale 1ns/1ps
module spi_bank_regfile
   import spi_bank_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int NUM_COMMON  = 5,
   parameter int SYNC_STAGES = 2,
   parameter logic [NUM_BANKS*(2**ADDR_W)-1:0] SLOW_MASK =
      {32'h0000_00FF, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000}
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);
   localparam int BANK_W = $clog2(NUM_BANKS);

   if (OP_W + ADDR_W != DATA_W) begin : g_bad_width
      $error("command byte must hold opcode plus address exactly");
   end
   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("bank count must be a power of two, at least 2");
   end
   if (NUM_COMMON < 1 || NUM_COMMON >= 2 ** ADDR_W) begin : g_bad_common
      $error("common window must fit inside the address span");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchronizer stages are required");
   end
   if (BANK_W > DATA_W) begin : g_bad_bsel
      $error("bank select does not fit in a register");
   end

   logic              sck_rise, sck_fall, cs_act, cs_start, cs_end, mosi_s;
   logic              byte_done, miso_bit, reset_armed;
   logic [DATA_W-1:0] byte_val, tx_next;
   logic [1:0]        byte_idx;
   logic [BANK_W-1:0] bank_sel;

   spi_bank_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n,
      .sck_pin(spi_sck), .cs_n_pin(spi_cs_n), .mosi_pin(spi_mosi),
      .sck_rise, .sck_fall, .cs_act, .cs_start, .cs_end, .mosi_s
   );

   spi_bank_frame #(.DATA_W(DATA_W)) u_frame (
      .clk, .rst_n, .sck_rise, .sck_fall, .cs_act, .cs_start, .mosi_s,
      .tx_next, .byte_done, .byte_val, .byte_idx, .miso_bit
   );

   spi_bank_regs #(
      .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .NUM_COMMON(NUM_COMMON), .SLOW_MASK(SLOW_MASK)
   ) u_regs (
      .clk, .rst_n, .byte_done, .byte_val, .byte_idx, .cs_end,
      .tx_next, .bank_sel, .reset_armed
   );

   assign spi_miso = spi_cs_n ? 1'bz : miso_bit;
endmodule

// File: rtl/spi_bank_regfile_chk.sv
`timescale 1ns/1ps
module spi_bank_regfile_chk #(
   parameter int DATA_W = 8,
   parameter int BANK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sck_fall,
   input logic              cs_act,
   input logic              cs_start,
   input logic              cs_end,
   input logic              byte_done,
   input logic [1:0]        byte_idx,
   input logic [DATA_W-1:0] byte_val,
   input logic [DATA_W-1:0] tx_next,
   input logic [BANK_W-1:0] bank_sel,
   input logic              reset_armed,
   input logic              miso_bit
);
   // R5
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_done && !cs_end) |=> $stable(bank_sel));

   // R8
   sys_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && reset_armed) |=> (bank_sel == '0));

   // R1
   miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !cs_start && !sck_fall) |=> $stable(miso_bit));

   // R10
   quiet_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && byte_idx == 2'd0 && byte_val[DATA_W-1 -: 3] != 3'b000) |=> (tx_next == '0));

   // R3
   tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && byte_idx >= 2'd2) |=> (tx_next == '0));
endmodule

bind spi_bank_regfile spi_bank_regfile_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/spi_bank_regfile_tb.sv
`timescale 1ns/1ps
module spi_bank_regfile_tb;
   localparam int HALF = 8;
   localparam logic [127:0] MASK = {32'h0000_00FF, 32'h0000_FFFF, 64'h0};

   logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   wire  miso;
   pullup (miso);

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   spi_bank_regfile u_dut (
      .clk, .rst_n, .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
   );

   // behavioural model of the register space
   logic [7:0] m_bank [4][27];
   logic [7:0] m_com  [5];

   function automatic int m_bsel();
      return int'(m_com[4][1:0]);
   endfunction
   function automatic bit m_slow(input int a);
      return (a < 27) && MASK[m_bsel()*32 + a];
   endfunction
   function automatic logic [7:0] m_rd(input int a);
      return (a >= 27) ? m_com[a-27] : m_bank[m_bsel()][a];
   endfunction
   task automatic m_wr(input int a, input logic [7:0] v);
      if (a >= 27) m_com[a-27] = v;
      else m_bank[m_bsel()][a] = v;
   endtask
   task automatic m_clear();
      for (int b = 0; b < 4; b++) for (int a = 0; a < 27; a++) m_bank[b][a] = 8'h00;
      for (int c = 0; c < 5; c++) m_com[c] = 8'h00;
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic xfer(input string req, input logic [23:0] tx, input int nbits);
      logic [23:0] got = '0;
      logic [23:0] exp = '0;
      logic [2:0]  op  = tx[23:21];
      int          a   = int'(tx[20:16]);
      logic [7:0]  d   = tx[15:8];
      if (op == 3'b000 && nbits >= 24)
         exp = m_slow(a) ? {16'h0000, m_rd(a)} : {8'h00, m_rd(a), 8'h00};
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = tx[23-i];
         repeat (HALF) @(negedge clk);
         got[23-i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      if (nbits >= 16) begin
         case (op)
            3'b010: m_wr(a, d);
            3'b100: if (!m_slow(a)) m_wr(a, m_rd(a) | d);
            3'b101: if (!m_slow(a)) m_wr(a, m_rd(a) & ~d);
            default: ;
         endcase
      end
      if (nbits >= 8 && tx[23:16] == 8'hFF) m_clear();
      check(req, $sformatf("miso bytes cmd=%h", tx[23:16]), {8'h00, got}, {8'h00, exp});
      repeat (HALF) @(negedge clk);
      // R11: released line is pulled high, so the target is not driving it
      check("R11", "miso idle", {31'd0, miso}, 32'd1);
   endtask

   task automatic rd(input string req, input logic [4:0] a);
      xfer(req, {3'b000, a, 16'h0000}, 24);
   endtask
   task automatic wr(input string req, input logic [4:0] a, input logic [7:0] v);
      xfer(req, {3'b010, a, v, 8'h00}, 16);
   endtask
   task automatic setb(input string req, input logic [4:0] a, input logic [7:0] v);
      xfer(req, {3'b100, a, v, 8'h00}, 16);
   endtask
   task automatic clrb(input string req, input logic [4:0] a, input logic [7:0] v);
      xfer(req, {3'b101, a, v, 8'h00}, 16);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      m_clear();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R11", "miso idle after reset", {31'd0, miso}, 32'd1);

      // R12: reset state
      rd("R12", 5'h1F);
      rd("R12", 5'h03);
      rd("R12", 5'h1C);

      // R2 / R1: write then read, asymmetric bit patterns
      wr("R2", 5'h03, 8'hA5);
      rd("R2", 5'h03);
      wr("R1", 5'h06, 8'h81);
      rd("R1", 5'h06);
      wr("R1", 5'h1A, 8'h4E);
      rd("R1", 5'h1A);

      // R5: banking
      wr("R5", 5'h1F, 8'h01);
      rd("R5", 5'h03);
      wr("R5", 5'h03, 8'h3C);
      rd("R5", 5'h03);
      wr("R5", 5'h1F, 8'h00);
      rd("R5", 5'h03);

      // R6: common window
      wr("R6", 5'h1F, 8'h01);
      wr("R6", 5'h1B, 8'h5A);
      wr("R6", 5'h1F, 8'h02);
      rd("R6", 5'h1B);
      rd("R6", 5'h1F);

      // R7: set and clear on common and banked fast registers
      setb("R7", 5'h1C, 8'h0F);
      clrb("R7", 5'h1C, 8'h05);
      rd("R7", 5'h1C);
      setb("R7", 5'h14, 8'h81);
      setb("R7", 5'h14, 8'h18);
      rd("R7", 5'h14);

      // R4: slow-class read (bank 2, address 4)
      wr("R4", 5'h04, 8'h77);
      rd("R4", 5'h04);
      // R7: set/clear ignored on slow-class
      setb("R7", 5'h04, 8'hFF);
      clrb("R7", 5'h04, 8'h07);
      rd("R7", 5'h04);
      // R3: fast register in the same bank
      rd("R3", 5'h14);

      // R9: aborted frames
      wr("R9", 5'h1F, 8'h00);
      xfer("R9", {3'b010, 5'h03, 8'h11, 8'h00}, 12);
      rd("R9", 5'h03);
      xfer("R9", {3'b010, 5'h1F, 8'h03, 8'h00}, 15);
      rd("R9", 5'h1F);
      xfer("R9", {3'b100, 5'h1C, 8'hF0, 8'h00}, 9);
      rd("R9", 5'h1C);

      // R10: buffer commands
      xfer("R10", {3'b001, 5'h1A, 16'hFFFF}, 24);
      xfer("R10", {3'b011, 5'h1A, 8'hEE, 8'h00}, 16);
      rd("R10", 5'h1A);
      rd("R10", 5'h03);

      // R8: system reset
      wr("R8", 5'h1F, 8'h03);
      wr("R8", 5'h05, 8'h99);
      xfer("R8", 24'hFF0000, 4);
      rd("R8", 5'h1F);
      rd("R8", 5'h05);
      xfer("R8", 24'hFF0000, 8);
      rd("R8", 5'h1F);
      rd("R8", 5'h05);
      rd("R8", 5'h1B);
      rd("R8", 5'h03);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule